// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a parallel NOR-style flash working in byte mode and watches every host write cycle (address, data and a one-cycle write enable). It follows the two-write unlock prefix, decodes the command byte that comes after it, and raises one-cycle strobes. These strobes tell the embedded controller to program a byte, erase a sector, erase the whole chip, reset, suspend or resume. It also keeps the read mode that selects what host reads return: array, identification (autoselect), CFI query or the secured sector. In identification mode it supplies the ID and protect-status byte for the offset being read.

The decoder also supports a bypass mode in which a program needs only two writes. Any write that breaks an expected address/data pair drops the decoder back to idle without a strobe. The array, the embedded timing, any write buffer and the physical strobe edge rules belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Strobes are registered. A strobe rises in the cycle after the write that completes its sequence and lasts exactly one cycle. At most one strobe is high in any cycle.
- R2: The program sequence is AAh@AAAh, 55h@555h, A0h@AAAh, then one write. That last write gives `pgm_stb` with `pgm_addr` equal to its full address and `pgm_data` equal to its data bits 7:0.
- R3: The erase sequence is AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h, then a sixth write. If that write is 10h@AAAh, `chip_erase_stb` pulses. If it is 30h at any address, `sec_erase_stb` pulses and `sec_addr` holds address bits ADDR_W-1:16.
- R4: A write of F0h at any address, made while no sequence is in progress and bypass is off, pulses `reset_stb` and sets `read_mode` to array (0). This is the way out of identification and CFI modes.
- R5: Unlock then 90h@AAAh sets `read_mode` to identification (1). In that mode `id_data` returns 01h at read offset 00h, DEVICE_CODE (7Eh by default) at 02h, {7'b0, `sector_prot`} at 04h, and 00h at other offsets. In every other mode `id_data` is 00h.
- R6: A single write of 98h at offset 0AAh sets `read_mode` to CFI (2), but only from array or identification mode. In CFI or secured mode the write leaves the mode unchanged.
- R7: Unlock then 88h@AAAh sets `read_mode` to secured (3). While in secured mode, unlock then 90h@AAAh then 00h at any address returns to array (0).
- R8: Unlock then 20h@AAAh sets `bypass_active`. While it is set, A0h at any address followed by one more write gives a program strobe as in R2. 90h followed by 00h clears `bypass_active`. F0h in bypass has no effect.
- R9: B0h pulses `suspend_stb` only while `erase_active` is high and no suspend is pending. 30h pulses `resume_stb` only while a suspend is pending. Otherwise both bytes have no effect.
- R10: A write that does not match the next expected address/data pair returns the sequence to idle with no strobe. A following full sequence is then decoded normally.
- R11: During unlock and command cycles, data bits above 7 and address bits above 11 are ignored.
- R12: After reset: `read_mode` is array, `bypass_active` is low, all strobes are low, and no suspend is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write qualifier |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command |
| erase_active | input | 1 | High while an embedded sector erase runs |
| rd_addr | input | 8 | Read offset for identification data |
| sector_prot | input | 1 | Protect status of the sector being read |
| pgm_stb | output | 1 | Program request |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | 8 | Program data byte |
| sec_erase_stb | output | 1 | Sector erase request |
| sec_addr | output | ADDR_W-16 | Sector selected for erase |
| chip_erase_stb | output | 1 | Chip erase request |
| reset_stb | output | 1 | Reset command seen |
| suspend_stb | output | 1 | Suspend request |
| resume_stb | output | 1 | Resume request |
| read_mode | output | 2 | 0 array, 1 identification, 2 CFI, 3 secured |
| bypass_active | output | 1 | Unlock-bypass mode is on |
| id_data | output | 8 | Identification read data |

## Verification
The hardest state to reach is the second half of an erase: five exact writes followed by the right sixth write. A secured-mode exit is similar, since it needs an entry and then a full unlock and 90h. Random writes almost never produce these, so the random pool is weighted toward the unlock addresses and the known command bytes, with random upper bits. Directed sequences cover each long path first. Suspend and resume are exercised while `erase_active` is toggled at random, so that both the honoured and the ignored cases occur.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_IDENT   = 2'd1,
        RM_CFI     = 2'd2,
        RM_SECURED = 2'd3
    } read_mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ER_UNL0,
        SQ_ER_UNL1,
        SQ_ER_FINAL,
        SQ_SEC_EXIT,
        SQ_BYP_PGM,
        SQ_BYP_EXIT
    } seq_e;

    typedef struct packed {
        logic pgm;
        logic sec_erase;
        logic chip_erase;
        logic reset;
        logic suspend;
        logic resume;
    } strobe_t;

    localparam logic [11:0] ADR_UNLOCK_A = 12'hAAA;
    localparam logic [11:0] ADR_UNLOCK_B = 12'h555;
    localparam logic [11:0] ADR_QUERY    = 12'h0AA;

    localparam logic [7:0] CB_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CB_UNLOCK_B = 8'h55;
    localparam logic [7:0] CB_IDENT    = 8'h90;
    localparam logic [7:0] CB_PROGRAM  = 8'hA0;
    localparam logic [7:0] CB_ERASE    = 8'h80;
    localparam logic [7:0] CB_SECURED  = 8'h88;
    localparam logic [7:0] CB_BYPASS   = 8'h20;
    localparam logic [7:0] CB_CHIP     = 8'h10;
    localparam logic [7:0] CB_SECTOR   = 8'h30;
    localparam logic [7:0] CB_RESET    = 8'hF0;
    localparam logic [7:0] CB_QUERY    = 8'h98;
    localparam logic [7:0] CB_SUSPEND  = 8'hB0;
    localparam logic [7:0] CB_EXIT     = 8'h00;

    function automatic logic any_strobe(input strobe_t s);
        return |s;
    endfunction

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_a,
    output logic              hit_b,
    output logic              hit_query
);
    localparam int CMP_W = 12;

    logic [CMP_W-1:0] low;
    assign low = addr[CMP_W-1:0];

    assign hit_a     = (low == ADR_UNLOCK_A);
    assign hit_b     = (low == ADR_UNLOCK_B);
    assign hit_query = (low == ADR_QUERY);
endmodule

// File: rtl/fcd_ident_rom.sv
module fcd_ident_rom
    import fcd_pkg::*;
#(
    parameter logic [7:0] DEVICE_CODE = 8'h7E
) (
    input  read_mode_e mode,
    input  logic [7:0] rd_addr,
    input  logic       sector_prot,
    output logic [7:0] id_data
);
    always_comb begin
        id_data = 8'h00;
        if (mode == RM_IDENT) begin
            case (rd_addr)
                8'h00:   id_data = 8'h01;
                8'h02:   id_data = DEVICE_CODE;
                8'h04:   id_data = {7'b0, sector_prot};
                default: id_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       erase_active,
    input  logic                       hit_a,
    input  logic                       hit_b,
    input  logic                       hit_query,
    output strobe_t                    stb,
    output logic [ADDR_W-1:0]          pgm_addr,
    output logic [7:0]                 pgm_data,
    output logic [ADDR_W-SECT_LSB-1:0] sec_addr,
    output read_mode_e                 mode,
    output logic                       bypass
);
    seq_e state;
    logic susp;
    logic [7:0] cb;

    assign cb = wr_data[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            mode     <= RM_ARRAY;
            bypass   <= 1'b0;
            susp     <= 1'b0;
            stb      <= '0;
            pgm_addr <= '0;
            pgm_data <= '0;
            sec_addr <= '0;
        end else begin
            stb <= '0;
            if (wr_en) begin
                state <= SQ_IDLE;
                case (state)
                    SQ_IDLE: begin
                        if (bypass) begin
                            if (cb == CB_PROGRAM)
                                state <= SQ_BYP_PGM;
                            else if (cb == CB_IDENT)
                                state <= SQ_BYP_EXIT;
                            else if (cb == CB_SUSPEND && erase_active && !susp) begin
                                stb.suspend <= 1'b1;
                                susp        <= 1'b1;
                            end else if (cb == CB_SECTOR && susp) begin
                                stb.resume <= 1'b1;
                                susp       <= 1'b0;
                            end
                        end else if (cb == CB_RESET) begin
                            stb.reset <= 1'b1;
                            mode      <= RM_ARRAY;
                        end else if (hit_a && cb == CB_UNLOCK_A) begin
                            state <= SQ_UNL1;
                        end else if (hit_query && cb == CB_QUERY) begin
                            if (mode == RM_ARRAY || mode == RM_IDENT)
                                mode <= RM_CFI;
                        end else if (cb == CB_SUSPEND && erase_active && !susp) begin
                            stb.suspend <= 1'b1;
                            susp        <= 1'b1;
                        end else if (cb == CB_SECTOR && susp) begin
                            stb.resume <= 1'b1;
                            susp       <= 1'b0;
                        end
                    end
                    SQ_UNL1: begin
                        if (hit_b && cb == CB_UNLOCK_B)
                            state <= SQ_UNL2;
                    end
                    SQ_UNL2: begin
                        if (hit_a) begin
                            case (cb)
                                CB_IDENT: begin
                                    if (mode == RM_SECURED)
                                        state <= SQ_SEC_EXIT;
                                    else
                                        mode <= RM_IDENT;
                                end
                                CB_PROGRAM: state  <= SQ_PGM;
                                CB_ERASE:   state  <= SQ_ER_UNL0;
                                CB_SECURED: mode   <= RM_SECURED;
                                CB_BYPASS:  bypass <= 1'b1;
                                default:    state  <= SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PGM, SQ_BYP_PGM: begin
                        stb.pgm  <= 1'b1;
                        pgm_addr <= wr_addr;
                        pgm_data <= cb;
                    end
                    SQ_ER_UNL0: begin
                        if (hit_a && cb == CB_UNLOCK_A)
                            state <= SQ_ER_UNL1;
                    end
                    SQ_ER_UNL1: begin
                        if (hit_b && cb == CB_UNLOCK_B)
                            state <= SQ_ER_FINAL;
                    end
                    SQ_ER_FINAL: begin
                        if (hit_a && cb == CB_CHIP) begin
                            stb.chip_erase <= 1'b1;
                        end else if (cb == CB_SECTOR) begin
                            stb.sec_erase <= 1'b1;
                            sec_addr      <= wr_addr[ADDR_W-1:SECT_LSB];
                        end
                    end
                    SQ_SEC_EXIT: begin
                        if (cb == CB_EXIT)
                            mode <= RM_ARRAY;
                    end
                    SQ_BYP_EXIT: begin
                        if (cb == CB_EXIT)
                            bypass <= 1'b0;
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    // R1: a strobe only follows an accepted write
    a_r1_strobe_after_write: assert property (@(posedge clk) disable iff (rst)
        any_strobe(stb) |-> $past(wr_en));

    // R1: strobes never overlap
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    // R9: suspend only while an erase was running
    a_r9_suspend_needs_erase: assert property (@(posedge clk) disable iff (rst)
        stb.suspend |-> $past(erase_active));

    // R8: bypass program step only exists in bypass mode
    a_r8_bypass_state: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_BYP_PGM || state == SQ_BYP_EXIT) |-> bypass);

    // R6: CFI entry only from array or identification mode
    a_r6_cfi_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == RM_CFI && $past(mode) != RM_CFI) |->
        ($past(mode) == RM_ARRAY || $past(mode) == RM_IDENT));

    // R10: the sequence state only moves on a write
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(state));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W      = 22,
    parameter int         DATA_W      = 16,
    parameter int         SECT_LSB    = 16,
    parameter logic [7:0] DEVICE_CODE = 8'h7E
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       erase_active,
    input  logic [7:0]                 rd_addr,
    input  logic                       sector_prot,
    output logic                       pgm_stb,
    output logic [ADDR_W-1:0]          pgm_addr,
    output logic [7:0]                 pgm_data,
    output logic                       sec_erase_stb,
    output logic [ADDR_W-SECT_LSB-1:0] sec_addr,
    output logic                       chip_erase_stb,
    output logic                       reset_stb,
    output logic                       suspend_stb,
    output logic                       resume_stb,
    output logic [1:0]                 read_mode,
    output logic                       bypass_active,
    output logic [7:0]                 id_data
);
    logic       hit_a, hit_b, hit_query;
    strobe_t    stb;
    read_mode_e mode;

    fcd_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr      (wr_addr),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .hit_query (hit_query)
    );

    fcd_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SECT_LSB (SECT_LSB)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .erase_active (erase_active),
        .hit_a        (hit_a),
        .hit_b        (hit_b),
        .hit_query    (hit_query),
        .stb          (stb),
        .pgm_addr     (pgm_addr),
        .pgm_data     (pgm_data),
        .sec_addr     (sec_addr),
        .mode         (mode),
        .bypass       (bypass_active)
    );

    fcd_ident_rom #(.DEVICE_CODE(DEVICE_CODE)) u_ident (
        .mode        (mode),
        .rd_addr     (rd_addr),
        .sector_prot (sector_prot),
        .id_data     (id_data)
    );

    assign pgm_stb        = stb.pgm;
    assign sec_erase_stb  = stb.sec_erase;
    assign chip_erase_stb = stb.chip_erase;
    assign reset_stb      = stb.reset;
    assign suspend_stb    = stb.suspend;
    assign resume_stb     = stb.resume;
    assign read_mode      = mode;

    // R5: identification data is zero outside identification mode
    a_r5_ident_gate: assert property (@(posedge clk) disable iff (rst)
        (read_mode != 2'd1) |-> (id_data == 8'h00));

    // R12: reset strobe coincides with array mode
    a_r12_reset_to_array: assert property (@(posedge clk) disable iff (rst)
        reset_stb |-> (read_mode == 2'd0));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int SW = AW - 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic erase_active = 1'b0;
    logic [7:0] rd_addr = '0;
    logic sector_prot = 1'b0;
    logic pgm_stb, sec_erase_stb, chip_erase_stb, reset_stb, suspend_stb, resume_stb;
    logic [AW-1:0] pgm_addr;
    logic [7:0] pgm_data;
    logic [SW-1:0] sec_addr;
    logic [1:0] read_mode;
    logic bypass_active;
    logic [7:0] id_data;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_active(erase_active), .rd_addr(rd_addr), .sector_prot(sector_prot),
        .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .sec_erase_stb(sec_erase_stb), .sec_addr(sec_addr),
        .chip_erase_stb(chip_erase_stb), .reset_stb(reset_stb),
        .suspend_stb(suspend_stb), .resume_stb(resume_stb),
        .read_mode(read_mode), .bypass_active(bypass_active), .id_data(id_data)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // bench reference state
    int m_st = 0;
    int m_mode = 0;
    bit m_byp = 0;
    bit m_susp = 0;
    logic [5:0] e_stb;
    logic [AW-1:0] e_pa;
    logic [7:0] e_pd;
    logic [SW-1:0] e_sa;

    function automatic logic [5:0] act_stb();
        return {pgm_stb, sec_erase_stb, chip_erase_stb, reset_stb, suspend_stb, resume_stb};
    endfunction

    task automatic model_susp(input logic [7:0] cb);
        if (cb == 8'hB0 && erase_active && !m_susp) begin
            e_stb[1] = 1'b1; m_susp = 1;
        end else if (cb == 8'h30 && m_susp) begin
            e_stb[0] = 1'b1; m_susp = 0;
        end
    endtask

    task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [7:0] cb = d[7:0];
        logic [11:0] lo = a[11:0];
        int ns = 0;
        e_stb = '0;
        case (m_st)
            0: begin
                if (m_byp) begin
                    if (cb == 8'hA0) ns = 8;
                    else if (cb == 8'h90) ns = 9;
                    else model_susp(cb);
                end else if (cb == 8'hF0) begin
                    e_stb[2] = 1'b1; m_mode = 0;
                end else if (lo == 12'hAAA && cb == 8'hAA) ns = 1;
                else if (lo == 12'h0AA && cb == 8'h98) begin
                    if (m_mode <= 1) m_mode = 2;
                end else model_susp(cb);
            end
            1: if (lo == 12'h555 && cb == 8'h55) ns = 2;
            2: if (lo == 12'hAAA) begin
                case (cb)
                    8'h90: if (m_mode == 3) ns = 7; else m_mode = 1;
                    8'hA0: ns = 3;
                    8'h80: ns = 4;
                    8'h88: m_mode = 3;
                    8'h20: m_byp = 1;
                    default: ns = 0;
                endcase
            end
            3, 8: begin e_stb[5] = 1'b1; e_pa = a; e_pd = cb; end
            4: if (lo == 12'hAAA && cb == 8'hAA) ns = 5;
            5: if (lo == 12'h555 && cb == 8'h55) ns = 6;
            6: if (lo == 12'hAAA && cb == 8'h10) e_stb[3] = 1'b1;
               else if (cb == 8'h30) begin e_stb[4] = 1'b1; e_sa = a[AW-1:16]; end
            7: if (cb == 8'h00) m_mode = 0;
            9: if (cb == 8'h00) m_byp = 0;
            default: ns = 0;
        endcase
        m_st = ns;
    endtask

    task automatic check(input string tag);
        bit bad = 0;
        n_tests++;
        if (act_stb() !== e_stb) bad = 1;
        if (e_stb[5] && (pgm_addr !== e_pa || pgm_data !== e_pd)) bad = 1;
        if (e_stb[4] && sec_addr !== e_sa) bad = 1;
        if (read_mode !== m_mode[1:0] || bypass_active !== m_byp) bad = 1;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: stb=%b mode=%0d byp=%0b pa=%h pd=%h sa=%h | exp stb=%b mode=%0d byp=%0b pa=%h pd=%h sa=%h",
                     tag, act_stb(), read_mode, bypass_active, pgm_addr, pgm_data, sec_addr,
                     e_stb, m_mode, m_byp, e_pa, e_pd, e_sa);
        end
    endtask

    // write on one cycle; outputs sampled at the following falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        model(a, d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(tag);
        @(negedge clk);
        e_stb = '0;
        check({tag, " (strobe drop)"});
    endtask

    task automatic unlock(input string tag);
        wr(22'h3F0AAA, 16'hC3AA, tag);
        wr(22'h155555, 16'h7E55, tag);
    endtask

    task automatic id_check(input logic [7:0] off, input logic prot, input logic [7:0] exp, input string tag);
        rd_addr = off; sector_prot = prot;
        #1;
        n_tests++;
        if (id_data !== exp) begin
            n_fail++;
            $display("FAIL %s: id_data=%h exp=%h", tag, id_data, exp);
        end
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        logic [AW-1:0] a = AW'($urandom);
        case ($urandom_range(0, 3))
            0: a[11:0] = 12'hAAA;
            1: a[11:0] = 12'h555;
            2: a[11:0] = 12'h0AA;
            default: ;
        endcase
        return a;
    endfunction

    function automatic logic [DW-1:0] pick_data();
        logic [7:0] pool [14] = '{8'hAA, 8'h55, 8'h90, 8'hA0, 8'h80, 8'h88, 8'h20,
                                  8'h10, 8'h30, 8'hF0, 8'h98, 8'hB0, 8'h00, 8'h5C};
        logic [DW-1:0] d = DW'($urandom);
        int k = $urandom_range(0, 15);
        if (k < 14) d[7:0] = pool[k];
        return d;
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        e_stb = '0; e_pa = '0; e_pd = '0; e_sa = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset state");

        // R2 program, upper data bits must not reach the byte
        unlock("R2 unlock"); wr(22'h000AAA, 16'h00A0, "R2 cmd");
        wr(22'h2ABCDE, 16'hFF5A, "R2 program strobe");

        // R3 chip and sector erase; R11 upper bits ignored
        unlock("R3"); wr(22'h3FFAAA, 16'hEE80, "R11 cmd upper bits");
        unlock("R3"); wr(22'h000AAA, 16'h0010, "R3 chip erase");
        unlock("R3"); wr(22'h000AAA, 16'h0080, "R3");
        unlock("R3"); wr(22'h2B1234, 16'h0030, "R3 sector erase");

        // R10 broken sequence then a good one
        wr(22'h000AAA, 16'h00AA, "R10"); wr(22'h000554, 16'h0055, "R10 bad addr");
        wr(22'h000AAA, 16'h00A0, "R10 no strobe");
        unlock("R10"); wr(22'h000AAA, 16'h0091, "R10 bad code");
        wr(22'h000123, 16'h0044, "R10 no program");

        // R5 identification
        unlock("R5"); wr(22'h000AAA, 16'h0090, "R5 enter");
        id_check(8'h00, 1'b0, 8'h01, "R5 manuf");
        id_check(8'h02, 1'b0, 8'h7E, "R5 device");
        id_check(8'h04, 1'b1, 8'h01, "R5 protected");
        id_check(8'h04, 1'b0, 8'h00, "R5 unprotected");
        id_check(8'h06, 1'b1, 8'h00, "R5 other");
        // R6 CFI from identification, R4 back to array
        wr(22'h1230AA, 16'h0098, "R6 cfi from ident");
        id_check(8'h00, 1'b0, 8'h00, "R5 gated in cfi");
        wr(22'h3FFFFF, 16'hABF0, "R4 reset");

        // R7 secured entry, CFI refused, exit
        unlock("R7"); wr(22'h000AAA, 16'h0088, "R7 enter");
        wr(22'h0000AA, 16'h0098, "R6 refused in secured");
        unlock("R7"); wr(22'h000AAA, 16'h0090, "R7 exit step");
        wr(22'h012345, 16'h0000, "R7 exit");

        // R8 bypass
        unlock("R8"); wr(22'h000AAA, 16'h0020, "R8 enter");
        wr(22'h000777, 16'h00F0, "R8 F0 ignored");
        wr(22'h000777, 16'h00A0, "R8 A0");
        wr(22'h1FEDCB, 16'h00C7, "R8 program");
        wr(22'h000001, 16'h0090, "R8 90"); wr(22'h000002, 16'h0000, "R8 exit");

        // R9 suspend / resume
        wr(22'h0, 16'h00B0, "R9 suspend ignored idle");
        wr(22'h0, 16'h0030, "R9 resume ignored");
        erase_active = 1'b1;
        wr(22'h0, 16'h00B0, "R9 suspend");
        wr(22'h0, 16'h00B0, "R9 second suspend ignored");
        wr(22'h0, 16'h0030, "R9 resume");
        erase_active = 1'b0;

        // R1 R10 R11 random mix
        for (int i = 0; i < 4000; i++) begin
            erase_active = ($urandom_range(0, 3) != 0);
            wr(pick_addr(), pick_data(), "R1 R10 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule